// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Bypass Lines

This block gathers a vector of level-sensitive interrupt lines behind a small word-addressed register interface. Each line's present level is visible as raw status. A software-written enable mask selects which lines contribute to one merged request. That request is registered and fed to one line of a primary vectored controller. A software-settable interrupt bit is ORed into line 0, so firmware can raise a request on its own.

A contiguous band of lines (21 to 30 by default) can also skip the merge. Each line in the band has its own bypass enable. While that enable is set, a registered copy of the line's level drives the matching bit of a bypass output vector, which goes straight to the primary controller. Bypass bits outside the band, and bits whose enable is clear, stay low.

Register writes take effect on the clock edge. Reads are combinational on the word address. Both outputs are registered, so they show a change of input level, enable mask or bypass enable one cycle after it happens.

Top module: `sic_top`

## Requirements
- R1: A read of word 1 (byte 0x04) returns the input levels, with the software interrupt bit ORed into bit 0.
- R2: A read of word 0 (byte 0x00) returns the word-1 raw value ANDed with the enable mask.
- R3: A write to word 2 (byte 0x08) ORs the written data into the enable mask. A read of word 2 returns the mask.
- R4: A write to word 3 (byte 0x0C) clears every enable mask bit that is 1 in the written data.
- R5: A nonzero write to word 4 (byte 0x10) sets the software interrupt bit, and a zero write there changes nothing. A read of word 4 returns raw bit 0 in bit 0, with all other bits zero.
- R6: A nonzero write to word 5 (byte 0x14) clears the software interrupt bit, and a zero write there changes nothing.
- R7: A write to word 8 (byte 0x20) ORs the written data into the bypass enable, but only bits BYP_LO..BYP_HI (21..30, mask 0x7FE00000) can ever be set. A read of word 8 returns the bypass enable.
- R8: A write to word 9 (byte 0x24) clears every bypass enable bit that is 1 in the written data.
- R9: One cycle after any change, each bypass output bit i in BYP_LO..BYP_HI equals input i ANDed with bypass enable i. All other bypass output bits are 0.
- R10: One cycle after any change, the merged request is high exactly when the raw value ANDed with the enable mask is nonzero.
- R11: The address is a word index over the whole window. Reads of words other than 0, 1, 2, 4 and 8 return zero, and writes to words other than 2, 3, 4, 5, 8 and 9 change nothing.
- R12: Reset clears the enable mask, the bypass enable, the software interrupt bit and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W-2 | Word index of the register access |
| bus_we | input | 1 | Write strobe for the current word |
| bus_wdata | input | NUM_IRQ | Write data |
| bus_rdata | output | NUM_IRQ | Combinational read data for bus_addr |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt lines |
| irq_merged | output | 1 | Registered merged request |
| irq_bypass | output | NUM_IRQ | Registered bypass lines for the primary controller |

## Verification
The merge is driven with lines that are enabled and lines that are masked. This shows that the output follows the AND with the mask and not the raw levels. A set and a clear of the same bit show that the two write words act on separate bits. The software bit is written with zero and nonzero data and seen on both the raw and the masked paths. The bypass is driven with all-ones enable data and with lines both inside and outside the band (bit 31 high). This shows the band limit on writes and on outputs. The latency checks sample one cycle before and one cycle after the change, so a path without a register, or with one register too many, is caught. Undefined words are read and written at both low and high word indices, which catches a decoder that looks at too few address bits.

// File: rtl/sic_pkg.sv
package sic_pkg;

   // word indices on the register bus
   localparam int unsigned W_MASKED  = 0;
   localparam int unsigned W_RAW     = 1;
   localparam int unsigned W_ENSET   = 2;
   localparam int unsigned W_ENCLR   = 3;
   localparam int unsigned W_SWSET   = 4;
   localparam int unsigned W_SWCLR   = 5;
   localparam int unsigned W_BYPSET  = 8;
   localparam int unsigned W_BYPCLR  = 9;
   localparam int unsigned W_MIN_BITS = 4;

   typedef struct packed {
      logic en_set;
      logic en_clr;
      logic sw_set;
      logic sw_clr;
      logic byp_set;
      logic byp_clr;
   } sic_wr_t;

   function automatic logic [63:0] span_mask(input int unsigned lo, input int unsigned hi);
      logic [63:0] m;
      for (int unsigned i = 0; i < 64; i++) m[i] = (i >= lo) && (i <= hi);
      return m;
   endfunction

endpackage

// File: rtl/sic_regif.sv
module sic_regif
   import sic_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned WORD_W  = 10
) (
   input  logic [WORD_W-1:0]  word,
   input  logic               we,
   input  logic [NUM_IRQ-1:0] wdata,
   input  logic [NUM_IRQ-1:0] raw_lvl,
   input  logic [NUM_IRQ-1:0] en_mask,
   input  logic [NUM_IRQ-1:0] byp_en,
   output sic_wr_t            wr,
   output logic [NUM_IRQ-1:0] rdata
);
   logic nz;
   assign nz = |wdata;

   always_comb begin
      wr = '0;
      if (we) begin
         case (word)
            WORD_W'(W_ENSET):  wr.en_set  = 1'b1;
            WORD_W'(W_ENCLR):  wr.en_clr  = 1'b1;
            WORD_W'(W_SWSET):  wr.sw_set  = nz;
            WORD_W'(W_SWCLR):  wr.sw_clr  = nz;
            WORD_W'(W_BYPSET): wr.byp_set = 1'b1;
            WORD_W'(W_BYPCLR): wr.byp_clr = 1'b1;
            default:           wr = '0;
         endcase
      end
   end

   always_comb begin
      case (word)
         WORD_W'(W_MASKED): rdata = raw_lvl & en_mask;
         WORD_W'(W_RAW):    rdata = raw_lvl;
         WORD_W'(W_ENSET):  rdata = en_mask;
         WORD_W'(W_SWSET):  rdata = {{(NUM_IRQ-1){1'b0}}, raw_lvl[0]};
         WORD_W'(W_BYPSET): rdata = byp_en;
         default:           rdata = '0;
      endcase
   end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
   import sic_pkg::*;
#(
   parameter int unsigned          NUM_IRQ  = 32,
   parameter logic [NUM_IRQ-1:0]   BYP_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sic_wr_t            wr,
   input  logic [NUM_IRQ-1:0] wdata,
   output logic [NUM_IRQ-1:0] en_mask,
   output logic [NUM_IRQ-1:0] byp_en,
   output logic               sw_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask <= '0;
      end else if (wr.en_set) begin
         en_mask <= en_mask | wdata;
      end else if (wr.en_clr) begin
         en_mask <= en_mask & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_en <= '0;
      end else if (wr.byp_set) begin
         byp_en <= byp_en | (wdata & BYP_MASK);
      end else if (wr.byp_clr) begin
         byp_en <= byp_en & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sw_bit <= 1'b0;
      else if (wr.sw_set)  sw_bit <= 1'b1;
      else if (wr.sw_clr)  sw_bit <= 1'b0;
   end
endmodule

// File: rtl/sic_bypass.sv
module sic_bypass #(
   parameter int unsigned BYP_LO = 21,
   parameter int unsigned BYP_HI = 30,
   localparam int unsigned N     = BYP_HI - BYP_LO + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] en,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= lvl[i] & en[i];
      end
   end
endmodule

// File: rtl/sic_merge.sv
module sic_merge #(
   parameter int unsigned NUM_IRQ = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] raw_lvl,
   input  logic [NUM_IRQ-1:0] en_mask,
   output logic               req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= |(raw_lvl & en_mask);
   end
endmodule

// File: rtl/sic_top.sv
module sic_top
   import sic_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BYP_LO  = 21,
   parameter int unsigned BYP_HI  = 30,
   localparam int unsigned WORD_W = ADDR_W - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [NUM_IRQ-1:0] bus_wdata,
   output logic [NUM_IRQ-1:0] bus_rdata,
   input  logic [NUM_IRQ-1:0] irq_in,
   output logic               irq_merged,
   output logic [NUM_IRQ-1:0] irq_bypass
);
   localparam int unsigned       BYP_N    = BYP_HI - BYP_LO + 1;
   localparam logic [NUM_IRQ-1:0] BYP_MASK = NUM_IRQ'(span_mask(BYP_LO, BYP_HI));

   if (NUM_IRQ < 1 || NUM_IRQ > 64) begin : g_bad_width
      $error("sic_top: NUM_IRQ out of range");
   end
   if (BYP_LO > BYP_HI || BYP_HI >= NUM_IRQ) begin : g_bad_band
      $error("sic_top: bypass band outside the line vector");
   end
   if (WORD_W < W_MIN_BITS) begin : g_bad_addr
      $error("sic_top: ADDR_W too small for the register words");
   end

   sic_wr_t            wr;
   logic [NUM_IRQ-1:0] en_mask;
   logic [NUM_IRQ-1:0] byp_en;
   logic               sw_bit;
   logic [NUM_IRQ-1:0] raw_lvl;
   logic [BYP_N-1:0]   byp_q;

   assign raw_lvl = irq_in | {{(NUM_IRQ-1){1'b0}}, sw_bit};

   sic_regif #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W)) u_regif (
      .word    (bus_addr),
      .we      (bus_we),
      .wdata   (bus_wdata),
      .raw_lvl (raw_lvl),
      .en_mask (en_mask),
      .byp_en  (byp_en),
      .wr      (wr),
      .rdata   (bus_rdata)
   );

   sic_regs #(.NUM_IRQ(NUM_IRQ), .BYP_MASK(BYP_MASK)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .wdata   (bus_wdata),
      .en_mask (en_mask),
      .byp_en  (byp_en),
      .sw_bit  (sw_bit)
   );

   sic_merge #(.NUM_IRQ(NUM_IRQ)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_lvl (raw_lvl),
      .en_mask (en_mask),
      .req     (irq_merged)
   );

   sic_bypass #(.BYP_LO(BYP_LO), .BYP_HI(BYP_HI)) u_bypass (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (irq_in[BYP_HI:BYP_LO]),
      .en    (byp_en[BYP_HI:BYP_LO]),
      .q     (byp_q)
   );

   always_comb begin
      irq_bypass = '0;
      irq_bypass[BYP_HI:BYP_LO] = byp_q;
   end
endmodule

// File: rtl/sic_chk.sv
module sic_chk
   import sic_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BYP_LO  = 21,
   parameter int unsigned BYP_HI  = 30,
   localparam int unsigned WORD_W = ADDR_W - 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [WORD_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [NUM_IRQ-1:0] bus_wdata,
   input logic [NUM_IRQ-1:0] bus_rdata,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic               irq_merged,
   input logic [NUM_IRQ-1:0] irq_bypass,
   input logic [NUM_IRQ-1:0] en_mask,
   input logic [NUM_IRQ-1:0] byp_en,
   input logic [NUM_IRQ-1:0] raw_lvl
);
   localparam logic [NUM_IRQ-1:0] BAND = NUM_IRQ'(span_mask(BYP_LO, BYP_HI));

   logic rd_defined;
   assign rd_defined = (bus_addr == WORD_W'(W_MASKED)) || (bus_addr == WORD_W'(W_RAW)) ||
                       (bus_addr == WORD_W'(W_ENSET))  || (bus_addr == WORD_W'(W_SWSET)) ||
                       (bus_addr == WORD_W'(W_BYPSET));

   // R10
   merged_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_merged == ($past(raw_lvl & en_mask) != '0)));

   // R9
   bypass_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_bypass == ($past(irq_in & byp_en) & BAND)));

   // R7
   bypass_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_en & ~BAND) == '0);

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == WORD_W'(W_ENSET)) |=> ((en_mask & $past(bus_wdata)) == $past(bus_wdata)));

   // R4
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == WORD_W'(W_ENCLR)) |=> ((en_mask & $past(bus_wdata)) == '0));

   // R11
   undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_defined |-> (bus_rdata == '0));
endmodule

bind sic_top sic_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BYP_LO(BYP_LO), .BYP_HI(BYP_HI)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .irq_in     (irq_in),
   .irq_merged (irq_merged),
   .irq_bypass (irq_bypass),
   .en_mask    (en_mask),
   .byp_en     (byp_en),
   .raw_lvl    (raw_lvl)
);

// File: tb/sim_sic_top.sv
module sim_sic_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [63:0] tag;
      logic [11:0] waddr;
      logic [31:0] wd;
      logic [31:0] irq;
      logic [11:0] raddr;
      logic [31:0] rd;
      logic        merged;
      logic [31:0] byp;
   } vec_t;

   // each row: write, then read; outputs checked after the read cycle
   localparam vec_t VECS [13] = '{
      '{"R3",  12'h008, 32'h0000_0011, 32'h0000_0010, 12'h008, 32'h0000_0011, 1'b1, 32'h0},
      '{"R2",  12'h008, 32'h0000_0100, 32'h0000_0000, 12'h000, 32'h0000_0000, 1'b0, 32'h0},
      '{"R4",  12'h00C, 32'h0000_0010, 32'h0000_0110, 12'h000, 32'h0000_0100, 1'b1, 32'h0},
      '{"R5",  12'h010, 32'h0000_0000, 32'h0000_0000, 12'h004, 32'h0000_0000, 1'b0, 32'h0},
      '{"R1",  12'h010, 32'h8000_0000, 32'h0000_0002, 12'h004, 32'h0000_0003, 1'b1, 32'h0},
      '{"R6",  12'h014, 32'h0000_0000, 32'h0000_0002, 12'h010, 32'h0000_0001, 1'b1, 32'h0},
      '{"R6",  12'h014, 32'h0000_0004, 32'h0000_0002, 12'h010, 32'h0000_0000, 1'b0, 32'h0},
      '{"R7",  12'h020, 32'hFFFF_FFFF, 32'h4020_0000, 12'h020, 32'h7FE0_0000, 1'b0, 32'h4020_0000},
      '{"R8",  12'h024, 32'h4000_0000, 32'hC060_0000, 12'h020, 32'h3FE0_0000, 1'b0, 32'h0060_0000},
      '{"R11", 12'h018, 32'hFFFF_FFFF, 32'h0000_0100, 12'h008, 32'h0000_0101, 1'b1, 32'h0},
      '{"R11", 12'h01C, 32'hFFFF_FFFF, 32'h0000_0000, 12'h018, 32'h0000_0000, 1'b0, 32'h0},
      '{"R9",  12'h028, 32'hFFFF_FFFF, 32'h0020_0000, 12'h020, 32'h3FE0_0000, 1'b0, 32'h0020_0000},
      '{"R11", 12'hFFC, 32'hFFFF_FFFF, 32'h0000_0000, 12'h808, 32'h0000_0000, 1'b0, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in = '0;
   logic        irq_merged;
   logic [31:0] irq_bypass;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sic_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .irq_merged(irq_merged), .irq_bypass(irq_bypass)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_we = 1'b0;
      bus_addr = a[11:2];
      #1;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      // R12: reset state with every line high
      irq_in = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd_chk("R12 mask", 12'h008, 32'h0);
      rd_chk("R12 bypass enable", 12'h020, 32'h0);
      rd_chk("R12 masked", 12'h000, 32'h0);
      chk("R12 merged", {31'b0, irq_merged}, 32'h0);
      chk("R12 bypass out", irq_bypass, 32'h0);
      irq_in = '0;
      @(negedge clk);

      foreach (VECS[k]) begin
         @(negedge clk);
         bus_addr = VECS[k].waddr[11:2];
         bus_wdata = VECS[k].wd;
         bus_we = 1'b1;
         irq_in = VECS[k].irq;
         @(negedge clk);
         bus_we = 1'b0;
         bus_wdata = '0;
         bus_addr = VECS[k].raddr[11:2];
         @(negedge clk);
         chk($sformatf("%s row %0d rdata", VECS[k].tag, k), bus_rdata, VECS[k].rd);
         chk($sformatf("%s/R10 row %0d merged", VECS[k].tag, k), {31'b0, irq_merged}, {31'b0, VECS[k].merged});
         chk($sformatf("%s/R9 row %0d bypass", VECS[k].tag, k), irq_bypass, VECS[k].byp);
      end
      // state now: mask 0x101, bypass enable 0x3FE00000, software bit clear

      // R10: one cycle of latency on the merged request
      irq_in = '0;
      @(negedge clk);
      irq_in = 32'h0000_0100;
      #1;
      chk("R10 before edge", {31'b0, irq_merged}, 32'h0);
      @(negedge clk);
      chk("R10 after edge", {31'b0, irq_merged}, 32'h1);

      // R9: one cycle of latency on a bypass line
      irq_in = 32'h0040_0000;
      #1;
      chk("R9 before edge", irq_bypass, 32'h0);
      @(negedge clk);
      chk("R9 after edge", irq_bypass, 32'h0040_0000);
      chk("R10 masked line drops", {31'b0, irq_merged}, 32'h0);

      // R8: clearing the bypass enable drops the line one cycle later
      bus_addr = 10'd9;
      bus_wdata = 32'h0040_0000;
      bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      chk("R8 still high one cycle", irq_bypass, 32'h0040_0000);
      @(negedge clk);
      chk("R8 dropped", irq_bypass, 32'h0);
      rd_chk("R8 enable readback", 12'h020, 32'h3FA0_0000);

      // R12: asynchronous reset mid-run
      irq_in = 32'h0020_0100;
      @(negedge clk);
      @(negedge clk);
      chk("R12 pre-reset merged", {31'b0, irq_merged}, 32'h1);
      rst_n = 1'b0;
      #1;
      chk("R12 merged cleared", {31'b0, irq_merged}, 32'h0);
      chk("R12 bypass cleared", irq_bypass, 32'h0);
      rd_chk("R12 mask cleared", 12'h008, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule